// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This unit sits in a transmit path and fills in a 16-bit ones-complement checksum field of an outgoing frame. Three 32-bit sideband header words are presented before each frame. They select whether offload is active, the first byte covered by the sum, the byte position where the result goes, and a 16-bit seed such as a pseudo-header partial sum. Bytes arrive on a byte-wide valid/ready stream and are stored in an internal buffer while the sum is accumulated. Because the checksum field normally lies ahead of the bytes it covers, the complete frame is replayed from the buffer with the result patched in.

A static transmit-control word gates the path. With its enable bit clear, frames are swallowed. With both its oversize-permit bits clear, frames of 1519 to 1522 bytes are also swallowed. Every frame that is sent produces a one-cycle transmit-complete pulse. The input stalls while a buffered frame is being replayed.

Top module: `tx_csum_insert`

## Requirements
- R1: After reset, s_tready is 1, m_tvalid is 0 and tx_done is 0.
- R2: When bit 0 of header word 0 is 0, a transmitted frame leaves byte for byte as it entered, with the same length and m_tlast on its final byte.
- R3: With offload on, the sum covers bytes from the offset in header word 1 bits 31:16 up to the last byte. Byte pairs are taken as big-endian 16-bit words counted from that offset, and an odd final byte counts as a high byte with a zero low byte. A start offset at or past the frame end gives an empty sum.
- R4: The seed in header word 2 bits 15:0 is added to the sum. The total is folded until no carry remains above bit 15, then inverted. The high byte replaces the byte at the offset in header word 1 bits 15:0 and the low byte the next one. A position at or past the frame end is not written.
- R5: When bit 28 of tx_ctrl is 0 at the frame's final byte, the frame is dropped: no output and no tx_done.
- R6: When bits 30 and 27 of tx_ctrl are both 0, frames of 1519 to 1522 bytes are dropped. Frames of 1518 or 1523 bytes, or any length with either bit set, are sent.
- R7: tx_done is high for exactly one cycle, the cycle after the handshake of a sent frame's final output byte. It never rises for dropped frames.
- R8: From the cycle after a sent frame's final input byte until its replay completes, s_tready is 0. Under m_tready low, m_tvalid and m_tdata hold.
- R9: Header words are captured when hdr_valid is high while s_tready is high. The last capture before a frame's final byte governs that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header words valid this cycle |
| hdr_w0 | input | 32 | Header word 0, bit 0 = offload enable |
| hdr_w1 | input | 32 | Header word 1, 31:16 sum start, 15:0 insert offset |
| hdr_w2 | input | 32 | Header word 2, 15:0 seed |
| tx_ctrl | input | 32 | Transmit control: 28 enable, 30 jumbo, 27 VLAN |
| s_tdata | input | 8 | Input byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tlast | input | 1 | Input byte is last of frame |
| s_tready | output | 1 | Input accepted |
| m_tdata | output | 8 | Output byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tlast | output | 1 | Output byte is last of frame |
| m_tready | input | 1 | Downstream ready |
| tx_done | output | 1 | Transmit-complete pulse |

## Verification
The first output byte of a sent frame is valid one cycle after the clock edge that accepts its final input byte. In that same cycle s_tready is already low. tx_done follows one cycle after the edge that hands over the last output byte. For a dropped frame, the cycles after the final input byte show s_tready high, m_tvalid low and no tx_done.

The bench drives inputs and samples outputs at falling edges, so each check falls in exactly the cycle those register counts predict. The bench throttles m_tready at random so that held output bytes are exercised.

// File: rtl/tx_csum_pkg.sv
// Shared types and arithmetic for the transmit checksum inserter.
package tx_csum_pkg;

    typedef enum logic {
        ST_RECV = 1'b0,
        ST_PLAY = 1'b1
    } csum_state_t;

    typedef struct packed {
        logic        ofl_en;
        logic [15:0] start;
        logic [15:0] ins;
        logic [15:0] seed;
    } csum_hdr_t;

    // Ones-complement fold of a 32-bit total; two passes clear every carry.
    function automatic logic [15:0] fold16(input logic [31:0] total);
        logic [31:0] a;
        logic [31:0] b;
        a = {16'b0, total[31:16]} + {16'b0, total[15:0]};
        b = {16'b0, a[31:16]} + {16'b0, a[15:0]};
        return b[15:0];
    endfunction

endpackage

// File: rtl/csum_accum.sv
// Running 32-bit sum of frame bytes as big-endian 16-bit words.
// Assumes the caller says whether the byte lies inside the summed range
// and whether it is the low (odd) byte of its word.
module csum_accum (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        clear,
    input  logic        in_range,
    input  logic        low_byte,
    input  logic [7:0]  data,
    output logic [31:0] sum_now
);
    logic [31:0] acc_q;
    logic [31:0] addend;

    // Weight the byte by its lane in the word.
    always_comb begin
        addend = 32'b0;
        if (en && in_range)
            addend = low_byte ? {24'b0, data} : {16'b0, data, 8'b0};
    end

    assign sum_now = acc_q + addend;

    // Accumulate, restarting at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= 32'b0;
        else if (clear) acc_q <= 32'b0;
        else            acc_q <= sum_now;
    end

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == 32'b0));

endmodule

// File: rtl/frame_store.sv
// Single-write, single-read frame buffer with an asynchronous read port.
// Assumes addresses stay below DEPTH.
module frame_store #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store one incoming byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tx_csum_insert.sv
// Transmit checksum inserter: buffers a frame, sums from a programmable
// start, folds with a seed, inverts, and replays the frame with the result
// patched in. Assumes tx_ctrl is stable during a frame and DEPTH < 65536.
// Bytes beyond DEPTH are not stored.
module tx_csum_insert
    import tx_csum_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hdr_valid,
    input  logic [31:0] hdr_w0,
    input  logic [31:0] hdr_w1,
    input  logic [31:0] hdr_w2,
    input  logic [31:0] tx_ctrl,
    input  logic [7:0]  s_tdata,
    input  logic        s_tvalid,
    input  logic        s_tlast,
    output logic        s_tready,
    output logic [7:0]  m_tdata,
    output logic        m_tvalid,
    output logic        m_tlast,
    input  logic        m_tready,
    output logic        tx_done
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [15:0] DEPTH_C = 16'(DEPTH);
    localparam int BIT_EN    = 28;
    localparam int BIT_JUMBO = 30;
    localparam int BIT_VLAN  = 27;

    csum_state_t state;
    csum_hdr_t   hdr_q;
    logic [15:0] cnt, len_q, rd_ptr;
    logic [15:0] csum_q;
    logic        done_q;
    logic [31:0] sum_now;
    logic [7:0]  rd_byte;
    logic        take, fin, keep, odd_size;
    logic [15:0] len_now;
    logic [16:0] ins_lo;
    logic        unused_bits;

    assign unused_bits = ^{hdr_w0[31:1], hdr_w2[31:16], tx_ctrl[31], tx_ctrl[29], tx_ctrl[26:0]};

    assign s_tready = (state == ST_RECV);
    assign take     = s_tvalid && s_tready;
    assign fin      = take && s_tlast;
    assign len_now  = cnt + ((cnt < DEPTH_C) ? 16'd1 : 16'd0);
    assign odd_size = (len_now >= 16'd1519) && (len_now <= 16'd1522);
    assign keep     = tx_ctrl[BIT_EN] && !(odd_size && !tx_ctrl[BIT_JUMBO] && !tx_ctrl[BIT_VLAN]);

    csum_accum u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (take),
        .clear    (fin),
        .in_range (cnt >= hdr_q.start),
        .low_byte (cnt[0] ^ hdr_q.start[0]),
        .data     (s_tdata),
        .sum_now  (sum_now)
    );

    frame_store #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (take && (cnt < DEPTH_C)),
        .waddr (cnt[AW-1:0]),
        .wdata (s_tdata),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_byte)
    );

    // Substitute checksum bytes at the insert position during replay.
    assign ins_lo = {1'b0, hdr_q.ins} + 17'd1;
    always_comb begin
        m_tdata = rd_byte;
        if (hdr_q.ofl_en && rd_ptr == hdr_q.ins)           m_tdata = csum_q[15:8];
        else if (hdr_q.ofl_en && {1'b0, rd_ptr} == ins_lo) m_tdata = csum_q[7:0];
    end

    assign m_tvalid = (state == ST_PLAY);
    assign m_tlast  = m_tvalid && (rd_ptr == len_q - 16'd1);
    assign tx_done  = done_q;

    // Frame sequencing: capture header, count input, replay output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RECV;
            hdr_q  <= '0;
            cnt    <= 16'd0;
            len_q  <= 16'd0;
            rd_ptr <= 16'd0;
            csum_q <= 16'd0;
        end else if (state == ST_RECV) begin
            if (hdr_valid)
                hdr_q <= '{ofl_en: hdr_w0[0], start: hdr_w1[31:16],
                           ins: hdr_w1[15:0], seed: hdr_w2[15:0]};
            if (take) cnt <= len_now;
            if (fin) begin
                cnt <= 16'd0;
                if (keep) begin
                    state  <= ST_PLAY;
                    len_q  <= len_now;
                    rd_ptr <= 16'd0;
                    csum_q <= ~fold16(sum_now + {16'b0, hdr_q.seed});
                end
            end
        end else if (m_tready) begin
            if (m_tlast) state <= ST_RECV;
            else         rd_ptr <= rd_ptr + 16'd1;
        end
    end

    // Completion pulse follows the final output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= m_tvalid && m_tready && m_tlast;
    end

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> !s_tready);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));
    p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(m_tvalid && m_tready && m_tlast));
    p_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (rd_ptr < len_q));

endmodule

// File: tb/tx_csum_insert_test.sv
module tx_csum_insert_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        hdr_valid;
    logic [31:0] hdr_w0, hdr_w1, hdr_w2, tx_ctrl;
    logic [7:0]  s_tdata;
    logic        s_tvalid, s_tlast, s_tready;
    logic [7:0]  m_tdata;
    logic        m_tvalid, m_tlast, m_tready, tx_done;

    int checks = 0;
    int fails  = 0;
    logic [7:0] ib [0:2047];
    logic [7:0] eb [0:2047];

    always #2 clk = ~clk;

    tx_csum_insert uut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected output bytes from the requirements (R3, R4).
    task automatic build_expected(input int len, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        longint sum;
        logic [15:0] cs;
        int st, ins;
        for (int i = 0; i < len; i++) eb[i] = ib[i];
        if (!w0[0]) return;
        st = int'(w1[31:16]);
        ins = int'(w1[15:0]);
        sum = 0;
        for (int i = st; i < len; i++)
            sum += ((i - st) % 2 == 0) ? (longint'(ib[i]) << 8) : longint'(ib[i]);
        sum += longint'(w2[15:0]);
        while (sum >> 16 != 0) sum = (sum & 64'hFFFF) + (sum >> 16);
        cs = ~sum[15:0];
        if (ins < len) eb[ins] = cs[15:8];
        if (ins + 1 < len) eb[ins + 1] = cs[7:0];
    endtask

    task automatic run_frame(input int len, input logic [31:0] w0, input logic [31:0] w1,
                             input logic [31:0] w2, input logic [31:0] ctl, input bit exp_keep,
                             input string req);
        int got;
        bit last_seen;
        bit data_ok;
        for (int i = 0; i < len; i++) ib[i] = 8'($urandom);
        build_expected(len, w0, w1, w2);
        @(negedge clk);
        tx_ctrl = ctl;
        hdr_valid = 1'b1; hdr_w0 = w0; hdr_w1 = w1; hdr_w2 = w2;   // R9 capture
        @(negedge clk);
        hdr_valid = 1'b0; hdr_w1 = 32'hDEAD_BEEF;
        for (int i = 0; i < len; i++) begin
            while ($urandom % 8 == 0) begin
                s_tvalid = 1'b0;
                @(negedge clk);
            end
            s_tvalid = 1'b1; s_tdata = ib[i]; s_tlast = (i == len - 1);
            @(negedge clk);
        end
        s_tvalid = 1'b0; s_tlast = 1'b0;
        if (!exp_keep) begin
            for (int k = 0; k < 4; k++) begin
                check(s_tready && !m_tvalid && !tx_done, {req, " drop"}, {s_tready, m_tvalid, tx_done}, 3'b100);
                @(negedge clk);
            end
            return;
        end
        check(!s_tready && m_tvalid, "R8 stall after last input", {s_tready, m_tvalid}, 2'b01);
        got = 0; last_seen = 0; data_ok = 1;
        while (!last_seen && got <= len) begin
            m_tready = ($urandom % 4 != 0);
            if (m_tvalid && m_tready) begin
                if (m_tdata !== eb[got]) begin
                    if (data_ok) check(0, {req, " byte"}, m_tdata, eb[got]);
                    data_ok = 0;
                end
                if (m_tlast) last_seen = 1;
                got++;
            end
            if (!last_seen && !s_tready && got > 0)
                ; // still replaying: input held off (R8)
            @(negedge clk);
        end
        m_tready = 1'b0;
        if (data_ok) check(1, req, 0, 0);
        check(got == len, {req, " length"}, got, len);
        check(tx_done && s_tready && !m_tvalid, "R7 done pulse", {tx_done, s_tready, m_tvalid}, 3'b110);
        @(negedge clk);
        check(!tx_done, "R7 single cycle", tx_done, 0);
    endtask

    localparam logic [31:0] CT_ON  = 32'h1000_0000;
    localparam logic [31:0] CT_JUM = 32'h5000_0000;
    localparam logic [31:0] CT_VLN = 32'h1800_0000;

    initial begin
        int unsigned seed0;
        seed0 = $urandom(32'd4711);
        rst_n = 1'b0; hdr_valid = 1'b0; hdr_w0 = 0; hdr_w1 = 0; hdr_w2 = 0;
        tx_ctrl = CT_ON; s_tdata = 0; s_tvalid = 0; s_tlast = 0; m_tready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(s_tready && !m_tvalid && !tx_done, "R1 reset state", {s_tready, m_tvalid, tx_done}, 3'b100);

        run_frame(40, 32'h0, 32'h000E_0010, 32'h1234, CT_ON, 1, "R2 pass-through");
        run_frame(41, 32'h1, 32'h000E_0018, 32'h0000, CT_ON, 1, "R3 odd tail");
        run_frame(30, 32'h1, 32'h0040_0004, 32'hABCD, CT_ON, 1, "R3 start past end");
        run_frame(30, 32'h1, 32'h0002_001D, 32'h0001, CT_ON, 1, "R4 insert at last byte");
        run_frame(20, 32'h1, 32'h0000_0000, 32'hFFFF, CT_ON, 1, "R4 seed carry fold");
        run_frame(20, 32'h1, 32'h0004_0000, 32'h0, 32'h0, 0, "R5 disabled");
        run_frame(25, 32'h1, 32'h0004_0006, 32'h55, CT_ON, 1, "R5 enabled after drop");
        run_frame(1519, 32'h1, 32'h000E_0020, 32'h0, CT_ON, 0, "R6 1519 dropped");
        run_frame(1522, 32'h0, 32'h0, 32'h0, CT_ON, 0, "R6 1522 dropped");
        run_frame(1518, 32'h1, 32'h000E_0020, 32'h7, CT_ON, 1, "R6 1518 sent");
        run_frame(1523, 32'h0, 32'h0, 32'h0, CT_ON, 1, "R6 1523 sent");
        run_frame(1520, 32'h1, 32'h0022_0028, 32'h9, CT_VLN, 1, "R6 vlan permits");
        run_frame(1521, 32'h0, 32'h0, 32'h0, CT_JUM, 1, "R6 jumbo permits");

        for (int n = 0; n < 24; n++) begin
            int len;
            logic [15:0] st, ins;
            len = 1 + int'($urandom % 160);
            st  = 16'($urandom % (len + 4));
            ins = 16'($urandom % (len + 2));
            run_frame(len, {31'b0, 1'($urandom)}, {st, ins}, $urandom, CT_ON, 1, "R9 random header R3 R4");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule